// File: doc/BRIEF.md
# 64-bit Cycle Counter with Torn-Read Detection

This block keeps a 64-bit free-running cycle counter and exposes it through a small register port of 32-bit words. Software turns counting on through a control word and reads the count as two halves, lower half first and upper half second. The counter keeps running between the two reads, so a carry from the lower half into the upper half can land between them and produce a value that never existed.

To make such a torn pair detectable, the block remembers the upper half at the moment the lower half is read. When the matching upper-half read arrives, it compares that record with the upper half it is about to return and latches the result into bit 31 of the control word. Software reads lower, upper, then control, and retries the whole sequence whenever bit 31 is 0.

The request port carries no ready signal: every request is taken in the cycle it is presented, and a read answers exactly one cycle later with a response valid pulse. There is no back-pressure on the response side. The two halves of the counter may also be loaded through the same port, which is how software sets a starting value.

Top module: `cyc64_atomic`

## Requirements
- R1: After reset the counter is 0, counting is off and the consistency flag is 0, so reads of control, lower and upper words all return 0.
- R2: Writing the control word (address 0x103) sets the enable from data bit 0; reading it returns the enable in bit 0, the consistency flag in bit 31 and 0 in bits 30 to 1.
- R3: While enabled the counter grows by exactly 1 per cycle, carrying from the lower half into the upper half; while disabled it holds its value.
- R4: A read request is answered in the next cycle with the response valid pulse high for one cycle; the returned half is the counter value in the request cycle. Writes give no response.
- R5: A read of the lower word (address 0x104) returns bits 31:0, records bits 63:32 of that cycle and clears the consistency flag.
- R6: A read of the upper word (address 0x105) that follows a lower-word read returns bits 63:32 and sets the flag to 1 only if the upper half equals the recorded one, otherwise to 0.
- R7: An upper-word read with no lower-word read pending since the last upper-word read leaves the flag unchanged.
- R8: A write to 0x104 or 0x105 loads that half with the write data; in that cycle the counter does not increment and the other half keeps its value.
- R9: Any other address reads as 0, and writes to it change neither the counter nor the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present; always accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
The two events that can coincide are the carry from the lower half into the upper half and the upper-word read that judges consistency. The bench loads the lower half just below its all-ones value, reads it, waits past the wrap and then reads the upper half, expecting a cleared flag and an upper half one above the loaded value; a back-to-back pair with no wrap must set the flag. Random traffic with lower-half loads near the wrap point then makes the carry land on every position relative to the read pair, and each returned word and flag is compared with a bench reference model.

// File: rtl/cyc64_pkg.sv
package cyc64_pkg;
  parameter int ADDR_W = 12;
  parameter int WORD_W = 32;
  parameter int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam addr_t ADDR_CTRL = 12'h103;
  localparam addr_t ADDR_LO   = 12'h104;
  localparam addr_t ADDR_HI   = 12'h105;

  localparam int FLAG_BIT = WORD_W - 1;
  localparam int EN_BIT   = 0;
endpackage

// File: rtl/cyc64_counter.sv
module cyc64_counter #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_lo) begin
      cnt[HALF_W-1:0] <= ld_data;
    end else if (ld_hi) begin
      cnt[CNT_W-1:HALF_W] <= ld_data;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + 1'b1));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_lo && !ld_hi) |=> $stable(cnt));
  p_load_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (cnt[HALF_W-1:0] == $past(ld_data)) && $stable(cnt[CNT_W-1:HALF_W]));
  p_load_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo) |=> (cnt[CNT_W-1:HALF_W] == $past(ld_data)) && $stable(cnt[HALF_W-1:0]));
endmodule

// File: rtl/cyc64_tear_track.sv
module cyc64_tear_track #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [HALF_W-1:0] cnt_hi,
  output logic              flag
);
  logic [HALF_W-1:0] snap_hi;
  logic              pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_hi <= '0;
      pending <= 1'b0;
      flag    <= 1'b0;
    end else if (rd_lo) begin
      snap_hi <= cnt_hi;
      pending <= 1'b1;
      flag    <= 1'b0;
    end else if (rd_hi && pending) begin
      pending <= 1'b0;
      flag    <= (snap_hi == cnt_hi);
    end
  end

  p_lo_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !flag);
  p_rise_needs_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rd_hi));
  p_idle_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |=> $stable(flag));
endmodule

// File: rtl/cyc64_rd_mux.sv
module cyc64_rd_mux
  import cyc64_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  addr_t            addr,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic             flag,
  output logic             rsp_valid,
  output word_t            rsp_rdata
);
  word_t sel;

  always_comb begin
    sel = '0;
    unique case (addr)
      ADDR_CTRL: begin
        sel[EN_BIT]   = en;
        sel[FLAG_BIT] = flag;
      end
      ADDR_LO: sel = cnt[HALF_W-1:0];
      ADDR_HI: sel = cnt[CNT_W-1:HALF_W];
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? sel : '0;
    end
  end

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  p_no_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  p_ctrl_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_CTRL) |=> (rsp_rdata[FLAG_BIT-1:EN_BIT+1] == '0));
endmodule

// File: rtl/cyc64_atomic.sv
module cyc64_atomic
  import cyc64_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  logic [CNT_W-1:0] cnt;
  logic             en;
  logic             flag;
  logic             wr, rd;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n)                       en <= 1'b0;
    else if (wr && req_addr == ADDR_CTRL) en <= req_wdata[EN_BIT];
  end

  cyc64_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ld_lo   (wr && req_addr == ADDR_LO),
    .ld_hi   (wr && req_addr == ADDR_HI),
    .ld_data (req_wdata[HALF_W-1:0]),
    .cnt     (cnt)
  );

  cyc64_tear_track #(.HALF_W(HALF_W)) u_tear (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_lo  (rd && req_addr == ADDR_LO),
    .rd_hi  (rd && req_addr == ADDR_HI),
    .cnt_hi (cnt[CNT_W-1:HALF_W]),
    .flag   (flag)
  );

  cyc64_rd_mux #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (rd),
    .addr      (req_addr),
    .cnt       (cnt),
    .en        (en),
    .flag      (flag),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0) && !en && !flag);
  p_other_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr != ADDR_CTRL) |=> $stable(en));
endmodule

// File: tb/cyc64_atomic_bench.sv
module cyc64_atomic_bench;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LO   = 12'h104;
  localparam logic [11:0] A_HI   = 12'h105;
  localparam logic [11:0] A_BAD  = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  cyc64_atomic u_cyc64_atomic (.*);

  // Reference model, updated at each clock edge
  logic [63:0] m_cnt;
  logic        m_en, m_flag, m_pend, exp_valid;
  logic [31:0] m_snap, exp_data;

  function automatic logic [31:0] model_read(logic [11:0] a, logic [63:0] c,
                                             logic en, logic fl);
    case (a)
      A_CTRL:  return {fl, 30'b0, en};
      A_LO:    return c[31:0];
      A_HI:    return c[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_en = 0; m_flag = 0; m_pend = 0; m_snap = '0;
      exp_valid = 0; exp_data = '0;
    end else begin
      exp_valid = req_valid && !req_write;
      exp_data  = exp_valid ? model_read(req_addr, m_cnt, m_en, m_flag) : 32'h0;
      if (exp_valid && req_addr == A_LO) begin
        m_snap = m_cnt[63:32]; m_pend = 1; m_flag = 0;
      end else if (exp_valid && req_addr == A_HI && m_pend) begin
        m_pend = 0; m_flag = (m_snap == m_cnt[63:32]);
      end
      if (req_valid && req_write && req_addr == A_LO)      m_cnt[31:0]  = req_wdata;
      else if (req_valid && req_write && req_addr == A_HI) m_cnt[63:32] = req_wdata;
      else if (m_en)                                       m_cnt = m_cnt + 1;
      if (req_valid && req_write && req_addr == A_CTRL) m_en = req_wdata[0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the response checked
  task automatic op(input bit w, input logic [11:0] a, input logic [31:0] d,
                    input string req);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (exp_valid) chk(rsp_valid && rsp_rdata == exp_data, req, rsp_rdata, exp_data);
    else           chk(!rsp_valid, {req, " no response on write (R4)"}, {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c64));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    op(0, A_CTRL, 0, "R1 ctrl after reset");
    chk(rsp_rdata == 32'h0, "R1 ctrl zero", rsp_rdata, 32'h0);
    op(0, A_LO, 0, "R1 low after reset");
    op(0, A_HI, 0, "R1 high after reset");
    chk(rsp_rdata == 32'h0, "R1 high zero", rsp_rdata, 32'h0);
    // R3: disabled counter holds
    idle(4);
    op(0, A_LO, 0, "R3 hold while disabled");
    chk(rsp_rdata == 32'h0, "R3 still zero", rsp_rdata, 32'h0);
    // R2: enable and read back
    op(1, A_CTRL, 32'h1, "R2 enable write");
    op(0, A_CTRL, 0, "R2 ctrl readback");
    chk(rsp_rdata == 32'h1, "R2 enable bit", rsp_rdata, 32'h1);
    // R8: load halves
    op(1, A_HI, 32'h0000_1234, "R8 load high");
    op(1, A_LO, 32'hFFFF_FFFC, "R8 load low");
    // R5/R6 torn pair: carry between low and high reads
    op(0, A_LO, 0, "R5 low read near wrap");
    chk(rsp_rdata == 32'hFFFF_FFFC, "R8 loaded low value", rsp_rdata, 32'hFFFF_FFFC);
    idle(5);
    op(0, A_HI, 0, "R3 carry into high");
    chk(rsp_rdata == 32'h0000_1235, "R3 carried high", rsp_rdata, 32'h0000_1235);
    op(0, A_CTRL, 0, "R6 torn flag");
    chk(rsp_rdata == 32'h0000_0001, "R6 flag clear on torn pair", rsp_rdata, 32'h1);
    // R6 consistent pair
    op(1, A_LO, 32'h0, "R8 load low zero");
    op(0, A_LO, 0, "R5 low read");
    op(0, A_HI, 0, "R6 high read");
    op(0, A_CTRL, 0, "R6 consistent flag");
    chk(rsp_rdata == 32'h8000_0001, "R6 flag set", rsp_rdata, 32'h8000_0001);
    // R7: lone high read keeps flag
    idle(2);
    op(0, A_HI, 0, "R7 lone high read");
    op(0, A_CTRL, 0, "R7 flag kept");
    chk(rsp_rdata[31] == 1'b1, "R7 flag still set", rsp_rdata, 32'h8000_0001);
    // R5: low read clears flag
    op(0, A_LO, 0, "R5 low read again");
    op(0, A_CTRL, 0, "R5 flag cleared");
    chk(rsp_rdata[31] == 1'b0, "R5 flag zero", rsp_rdata, 32'h1);
    // R9: unmapped address
    op(1, A_BAD, 32'hFFFF_FFFF, "R9 unmapped write");
    op(0, A_BAD, 0, "R9 unmapped read");
    chk(rsp_rdata == 32'h0, "R9 reads zero", rsp_rdata, 32'h0);
    op(0, A_CTRL, 0, "R9 ctrl untouched");
    // R3: disable holds
    op(1, A_CTRL, 32'h0, "R2 disable");
    op(0, A_LO, 0, "R3 hold a");
    idle(3);
    op(0, A_LO, 0, "R3 hold b");
    // Random traffic
    op(1, A_CTRL, 32'h1, "R2 re-enable");
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [11:0] a;
      logic [31:0] d;
      k = $urandom_range(0, 19);
      case ($urandom_range(0, 3))
        0: a = A_CTRL; 1: a = A_LO; 2: a = A_HI; default: a = A_BAD;
      endcase
      d = $urandom();
      if (a == A_LO) d = 32'hFFFF_FFFF - $urandom_range(0, 6);
      if (a == A_CTRL) d = (k < 18) ? 32'h1 : d;
      if (k < 3) op(1, a, d, "R8 random write");
      else if (k < 5) idle($urandom_range(1, 4));
      else begin
        op(0, A_LO, 0, "R5 random low");
        if (k & 1) idle($urandom_range(0, 5));
        op(0, A_HI, 0, "R6 random high");
        op(0, A_CTRL, 0, "R6 random flag");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule